// File: doc/BRIEF.md
# Sync Output Formatter with Deferred Control Register

This block shapes the four sync outputs of a video capture front end: a regenerated HSYNC, a regenerated VSYNC, a general-purpose HS and a general-purpose VS. Each output has its own enable. Its inputs are:

- a one-clock lock-edge pulse taken from the selected horizontal sync;
- a VSYNC level, either extracted internally or supplied from outside;
- a coast level that already includes its pre- and post-coast extensions;
- a pixel strobe, which sets the time base for pulse widths.

One 8-bit control register, written through a simple write port, sets the behaviour:

- whether the sync outputs are enabled;
- the polarity of the coast input;
- whether the HS pulse is anchored to the lock edge at its leading or at its trailing end;
- whether VSYNC is re-timed to HSYNC or passed through raw;
- whether the VS pin carries vertical sync or coast.

A write is staged at once but only applied at the next lock edge, together with the requested HS width. A pulse already on the outputs therefore always finishes with the settings it started with. In trailing-anchored mode the block measures the length of the previous line in pixel strobes and starts the pulse early enough that it ends at the next lock edge.

Top module: `sync_fmt_top`

## Requirements
- R1: After reset the control register reads 0x00, all four bits of `out_en` are 1, and `hsync_o`, `vsync_o`, `hs_o` and `vs_o` are 0.
- R2: `reg_rdata` shows the last written value on the clock after the write, with bits 3, 5 and 6 always reading 0. Writing 0xFF reads back 0x97, and writing 0x68 reads back 0x00.
- R3: With control bit 0 = 1 applied, all four `out_en` bits are 0. With bit 0 = 0 applied, all four are 1. `out_en` changes on the second clock after the lock edge that applies the setting.
- R4: With control bit 2 = 1 (leading anchor) and width W, `hsync_o` and `hs_o` rise one clock after the lock-edge clock and stay high for W pixel strobes. W = 0 gives no pulse.
- R5: With control bit 2 = 0 (trailing anchor), line period P and width W, both HS outputs are high for W strobes and fall one clock after the lock edge. Counted from the previous lock edge, the pulse is high at offsets P-W+1 through P. No pulse is produced until two lock edges have been seen.
- R6: With control bit 4 = 0, `vsync_o` takes the value of `vsync_in` and changes only on the clock where `hsync_o` rises. A raw transition becomes visible at the first HSYNC leading edge that follows it.
- R7: With control bit 4 = 1, `vsync_o` equals `vsync_in` as sampled one clock earlier.
- R8: With control bit 7 = 0, `vs_o` equals `vsync_in` delayed by one clock. With bit 7 = 1, `vs_o` carries active-high coast, which is `coast_in` XOR control bit 1, delayed by one clock.
- R9: Control writes and changes to `hs_width` take effect only at the next lock edge. A pulse that is in progress when the write happens completes with its old width and mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_stb | input | 1 | Pixel strobe that advances the line counter |
| hs_lock | input | 1 | One-clock pulse at the selected HSYNC lock edge |
| vsync_in | input | 1 | Raw VSYNC (internally extracted or external) |
| coast_in | input | 1 | Coast level including pre/post extensions |
| hs_width | input | WID_W | Requested HS width in pixel strobes, sampled at lock |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Staged control register value |
| hsync_o | output | 1 | Regenerated HSYNC |
| vsync_o | output | 1 | Regenerated VSYNC (aligned or raw) |
| hs_o | output | 1 | General HS output |
| vs_o | output | 1 | General VS output (VS or coast) |
| out_en | output | 4 | Output enables: bit0 hsync, bit1 vsync, bit2 hs, bit3 vs |

## Verification
Some properties are checked on every cycle:

- in leading-anchor mode an HS rise only follows a lock edge;
- in trailing-anchor mode an HS fall only follows a lock edge;
- an aligned VSYNC change always coincides with an HSYNC rise;
- raw VSYNC tracks its input one clock behind;
- the output enables move only after a lock edge.

Other behaviour can only be shown by the bench scenarios:

- the exact pulse placement computed from the measured line period;
- a pulse left intact when a write arrives in the middle of it;
- the reserved-bit masking on readback;
- the coast polarity on the VS pin.

// File: rtl/sync_fmt_pkg.sv
package sync_fmt_pkg;
  localparam int CTRL_W = 8;
  localparam int N_OUT = 4;
  localparam logic [CTRL_W-1:0] CTRL_RST = 8'h00;
  localparam logic [CTRL_W-1:0] CTRL_MASK = 8'h97;

  typedef struct packed {
    logic vs_coast;
    logic rsv6;
    logic rsv5;
    logic vs_raw;
    logic rsv3;
    logic hs_lead;
    logic coast_low;
    logic hiz;
  } ctrl_t;
endpackage

// File: rtl/sync_fmt_ctrl.sv
module sync_fmt_ctrl
  import sync_fmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [CTRL_W-1:0] wdata,
  input  logic              lock,
  output logic [CTRL_W-1:0] rdata,
  output logic              lead_nxt,
  output logic              act_hiz,
  output logic              act_coast_low,
  output logic              act_lead,
  output logic              act_vs_raw,
  output logic              act_vs_coast
);
  ctrl_t pend;
  ctrl_t act;
  ctrl_t nxt;

  // staged value becomes active only on a lock edge
  assign nxt = lock ? pend : act;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= ctrl_t'(CTRL_RST);
      act  <= ctrl_t'(CTRL_RST);
    end else begin
      if (we) pend <= ctrl_t'(wdata & CTRL_MASK);
      act <= nxt;
    end
  end

  assign rdata         = pend;
  assign lead_nxt      = nxt.hs_lead;
  assign act_hiz       = act.hiz;
  assign act_coast_low = act.coast_low;
  assign act_lead      = act.hs_lead;
  assign act_vs_raw    = act.vs_raw;
  assign act_vs_coast  = act.vs_coast;
endmodule

// File: rtl/sync_fmt_hsgen.sv
module sync_fmt_hsgen #(
  parameter int CNT_W = 12,
  parameter int WID_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pix_stb,
  input  logic             lock,
  input  logic             lead,
  input  logic [WID_W-1:0] width_in,
  output logic             hs_q,
  output logic             hs_rise
);
  localparam int SUM_W = CNT_W + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt, per, cnt_nxt, per_nxt;
  logic [WID_W-1:0] wid, wid_nxt;
  logic             seen, pvalid, seen_nxt, pvalid_nxt, hs_nxt;
  logic [SUM_W-1:0] tail_sum;

  always_comb begin
    if (lock)
      cnt_nxt = '0;
    else if (pix_stb && (cnt != CNT_MAX))
      cnt_nxt = cnt + CNT_W'(1);
    else
      cnt_nxt = cnt;

    if (lock)
      per_nxt = (cnt == CNT_MAX) ? cnt : cnt + CNT_W'(1);
    else
      per_nxt = per;

    wid_nxt    = lock ? width_in : wid;
    seen_nxt   = seen | lock;
    pvalid_nxt = lock ? seen : pvalid;
    tail_sum   = SUM_W'(cnt_nxt) + SUM_W'(wid_nxt);

    if (lead)
      hs_nxt = seen_nxt && (SUM_W'(cnt_nxt) < SUM_W'(wid_nxt));
    else
      hs_nxt = pvalid_nxt && (wid_nxt != '0) && (tail_sum >= SUM_W'(per_nxt));
  end

  assign hs_rise = hs_nxt & ~hs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      per    <= '0;
      wid    <= '0;
      seen   <= 1'b0;
      pvalid <= 1'b0;
      hs_q   <= 1'b0;
    end else begin
      cnt    <= cnt_nxt;
      per    <= per_nxt;
      wid    <= wid_nxt;
      seen   <= seen_nxt;
      pvalid <= pvalid_nxt;
      hs_q   <= hs_nxt;
    end
  end
endmodule

// File: rtl/sync_fmt_valign.sv
module sync_fmt_valign (
  input  logic clk,
  input  logic rst,
  input  logic hs_rise,
  input  logic vsync_in,
  output logic vs_al
);
  always_ff @(posedge clk) begin
    if (rst)
      vs_al <= 1'b0;
    else if (hs_rise)
      vs_al <= vsync_in;
  end
endmodule

// File: rtl/sync_fmt_outs.sv
module sync_fmt_outs
  import sync_fmt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             hiz,
  input  logic             coast_low,
  input  logic             vs_raw,
  input  logic             vs_coast,
  input  logic             hs_q,
  input  logic             vs_al,
  input  logic             vsync_in,
  input  logic             coast_in,
  output logic             hsync_o,
  output logic             vsync_o,
  output logic             hs_o,
  output logic             vs_o,
  output logic [N_OUT-1:0] out_en
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hsync_o <= 1'b0;
      vsync_o <= 1'b0;
      hs_o    <= 1'b0;
      vs_o    <= 1'b0;
      out_en  <= '1;
    end else begin
      hsync_o <= hs_q;
      hs_o    <= hs_q;
      vsync_o <= vs_raw ? vsync_in : vs_al;
      vs_o    <= vs_coast ? (coast_in ^ coast_low) : vsync_in;
      out_en  <= {N_OUT{~hiz}};
    end
  end
endmodule

// File: rtl/sync_fmt_top.sv
module sync_fmt_top
  import sync_fmt_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int WID_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pix_stb,
  input  logic              hs_lock,
  input  logic              vsync_in,
  input  logic              coast_in,
  input  logic [WID_W-1:0]  hs_width,
  input  logic              reg_we,
  input  logic [CTRL_W-1:0] reg_wdata,
  output logic [CTRL_W-1:0] reg_rdata,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              hs_o,
  output logic              vs_o,
  output logic [N_OUT-1:0]  out_en
);
  logic lead_nxt, act_hiz, act_coast_low, act_lead, act_vs_raw, act_vs_coast;
  logic hs_q, hs_rise, vs_al;

  sync_fmt_ctrl u_ctrl (
    .clk(clk), .rst(rst), .we(reg_we), .wdata(reg_wdata), .lock(hs_lock),
    .rdata(reg_rdata), .lead_nxt(lead_nxt), .act_hiz(act_hiz),
    .act_coast_low(act_coast_low), .act_lead(act_lead),
    .act_vs_raw(act_vs_raw), .act_vs_coast(act_vs_coast)
  );

  sync_fmt_hsgen #(.CNT_W(CNT_W), .WID_W(WID_W)) u_hsgen (
    .clk(clk), .rst(rst), .pix_stb(pix_stb), .lock(hs_lock), .lead(lead_nxt),
    .width_in(hs_width), .hs_q(hs_q), .hs_rise(hs_rise)
  );

  sync_fmt_valign u_valign (
    .clk(clk), .rst(rst), .hs_rise(hs_rise), .vsync_in(vsync_in), .vs_al(vs_al)
  );

  sync_fmt_outs u_outs (
    .clk(clk), .rst(rst), .hiz(act_hiz), .coast_low(act_coast_low),
    .vs_raw(act_vs_raw), .vs_coast(act_vs_coast), .hs_q(hs_q), .vs_al(vs_al),
    .vsync_in(vsync_in), .coast_in(coast_in), .hsync_o(hsync_o),
    .vsync_o(vsync_o), .hs_o(hs_o), .vs_o(vs_o), .out_en(out_en)
  );
endmodule

// File: rtl/sync_fmt_chk.sv
module sync_fmt_chk
  import sync_fmt_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             hs_lock,
  input logic             vsync_in,
  input logic             hsync_o,
  input logic             vsync_o,
  input logic [N_OUT-1:0] out_en,
  input logic             lead_act,
  input logic             raw_act
);
  // R4
  lead_rise_at_lock_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(hsync_o) && $past(lead_act)) |-> $past(hs_lock, 2));

  // R5
  trail_fall_at_lock_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(hsync_o) && !$past(lead_act)) |-> $past(hs_lock, 2));

  // R6
  vsync_aligned_chk: assert property (@(posedge clk) disable iff (rst)
    (!$stable(vsync_o) && !raw_act && !$past(raw_act) && !$past(raw_act, 2))
      |-> $rose(hsync_o));

  // R7
  vsync_raw_follow_chk: assert property (@(posedge clk) disable iff (rst)
    $past(raw_act) |-> (vsync_o == $past(vsync_in)));

  // R9
  oe_change_at_lock_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(out_en) |-> $past(hs_lock, 2));
endmodule

bind sync_fmt_top sync_fmt_chk i_chk (
  .clk(clk), .rst(rst), .hs_lock(hs_lock), .vsync_in(vsync_in),
  .hsync_o(hsync_o), .vsync_o(vsync_o), .out_en(out_en),
  .lead_act(act_lead), .raw_act(act_vs_raw)
);

// File: tb/test_sync_fmt_top.sv
module test_sync_fmt_top;
  localparam int CLK_PERIOD = 10;
  localparam int N_VEC = 9;
  // fields: cfg[39:32] width[31:24] period[23:16] first_high[15:8] oe[3:0]
  localparam logic [39:0] VEC [N_VEC] = '{
    {8'h04, 8'd3, 8'd10, 8'd1,  8'h0F},
    {8'h04, 8'd5, 8'd16, 8'd1,  8'h0F},
    {8'h00, 8'd3, 8'd10, 8'd8,  8'h0F},
    {8'h00, 8'd6, 8'd20, 8'd15, 8'h0F},
    {8'h00, 8'd1, 8'd8,  8'd8,  8'h0F},
    {8'h04, 8'd0, 8'd8,  8'd0,  8'h0F},
    {8'h02, 8'd4, 8'd12, 8'd9,  8'h0F},
    {8'h84, 8'd2, 8'd9,  8'd1,  8'h0F},
    {8'h05, 8'd2, 8'd8,  8'd1,  8'h00}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pix_stb = 1'b1;
  logic hs_lock = 1'b0;
  logic vsync_in = 1'b0;
  logic coast_in = 1'b0;
  logic [7:0] hs_width = 8'd0;
  logic reg_we = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic hsync_o, vsync_o, hs_o, vs_o;
  logic [3:0] out_en;

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;
  int hcnt, hfirst, hmis;
  logic hrec [0:63];
  logic vrec [0:63];

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_fmt_top i_sync_fmt_top (
    .clk(clk), .rst(rst), .pix_stb(pix_stb), .hs_lock(hs_lock),
    .vsync_in(vsync_in), .coast_in(coast_in), .hs_width(hs_width),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .hs_o(hs_o), .vs_o(vs_o),
    .out_en(out_en)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 100000);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [7:0] v);
    reg_we = 1'b1;
    reg_wdata = v;
    step();
    reg_we = 1'b0;
  endtask

  task automatic run_line(input int len, input int wr_at, input logic [7:0] wr_val,
                          input logic [7:0] wid_val, input int vs_at, input logic vs_val);
    hcnt = 0;
    hfirst = 0;
    hmis = 0;
    for (int j = 1; j <= len; j++) begin
      hs_lock = (j == len);
      if (j == wr_at) begin
        reg_we = 1'b1;
        reg_wdata = wr_val;
        hs_width = wid_val;
      end
      if (j == vs_at) vsync_in = vs_val;
      step();
      reg_we = 1'b0;
      hs_lock = 1'b0;
      hrec[j] = hs_o;
      vrec[j] = vsync_o;
      if (hs_o) begin
        hcnt++;
        if (hfirst == 0) hfirst = j;
      end
      if (hsync_o != hs_o) hmis++;
    end
  endtask

  task automatic plain_line(input int len);
    run_line(len, 0, 8'h00, 8'h00, 0, 1'b0);
  endtask

  initial begin
    int vz;
    repeat (5) step();
    rst = 1'b0;
    step();
    // R1 reset state
    chk(reg_rdata == 8'h00, "R1 rdata", reg_rdata, 0);
    chk(out_en == 4'hF, "R1 out_en", out_en, 15);
    chk({hsync_o, vsync_o, hs_o, vs_o} == 4'b0, "R1 outputs", {hsync_o, vsync_o, hs_o, vs_o}, 0);

    // R2 readback with reserved bits masked; R9 no effect before lock
    wr(8'hFF);
    chk(reg_rdata == 8'h97, "R2 rdata after 0xFF", reg_rdata, 8'h97);
    step();
    chk(out_en == 4'hF, "R9 out_en before lock", out_en, 15);
    wr(8'h68);
    chk(reg_rdata == 8'h00, "R2 rdata after 0x68", reg_rdata, 0);

    // table walk: R4 / R5 placement, R3 enables
    for (int v = 0; v < N_VEC; v++) begin
      wr(VEC[v][39:32]);
      hs_width = VEC[v][31:24];
      repeat (2) plain_line(int'(VEC[v][23:16]));
      plain_line(int'(VEC[v][23:16]));
      chk(hcnt == int'(VEC[v][31:24]), VEC[v][34] ? "R4 width" : "R5 width",
          hcnt, int'(VEC[v][31:24]));
      chk(hfirst == int'(VEC[v][15:8]), VEC[v][34] ? "R4 first offset" : "R5 first offset",
          hfirst, int'(VEC[v][15:8]));
      chk(hmis == 0, "R4 hsync equals hs", hmis, 0);
      chk(out_en == VEC[v][3:0], "R3 out_en", out_en, int'(VEC[v][3:0]));
    end

    // R3 / R9: enable restore waits for lock, visible two clocks later
    wr(8'h04);
    step();
    chk(out_en == 4'h0, "R9 out_en held until lock", out_en, 0);
    hs_lock = 1'b1;
    step();
    hs_lock = 1'b0;
    chk(out_en == 4'h0, "R3 out_en at lock clock", out_en, 0);
    step();
    chk(out_en == 4'hF, "R3 out_en driven", out_en, 15);

    // R5 no pulse before two locks after reset
    rst = 1'b1;
    step();
    rst = 1'b0;
    hs_width = 8'd3;
    plain_line(10);
    plain_line(10);
    chk(hcnt == 0, "R5 no pulse before period known", hcnt, 0);
    plain_line(10);
    chk(hcnt == 3 && hfirst == 8, "R5 pulse after two locks", hfirst, 8);

    // R9 mid-pulse write does not truncate; new setting at next lock
    wr(8'h04);
    hs_width = 8'd4;
    repeat (3) plain_line(12);
    run_line(12, 2, 8'h00, 8'd2, 0, 1'b0);
    chk(hcnt == 4 && hfirst == 1, "R9 pulse kept width 4", hcnt, 4);
    chk(reg_rdata == 8'h00, "R2 staged value visible", reg_rdata, 0);
    plain_line(12);
    chk(hcnt == 2 && hfirst == 11, "R9 new trailing setting", hfirst, 11);

    // R6 aligned vsync
    vsync_in = 1'b0;
    wr(8'h04);
    hs_width = 8'd2;
    repeat (2) plain_line(10);
    run_line(10, 0, 8'h00, 8'h00, 4, 1'b1);
    vz = 0;
    for (int j = 1; j <= 10; j++) if (vrec[j]) vz++;
    chk(vz == 0, "R6 vsync held until hsync edge", vz, 0);
    plain_line(10);
    chk(vrec[1] == 1'b1 && hrec[1] == 1'b1, "R6 vsync with hsync rise", vrec[1], 1);

    // R7 raw vsync
    wr(8'h14);
    plain_line(10);
    vsync_in = 1'b0;
    step();
    chk(vsync_o == 1'b0, "R7 raw low", vsync_o, 0);
    vsync_in = 1'b1;
    step();
    chk(vsync_o == 1'b1, "R7 raw high", vsync_o, 1);
    vsync_in = 1'b0;
    step();
    chk(vsync_o == 1'b0, "R7 raw low again", vsync_o, 0);

    // R8 VS pin routing and coast polarity
    wr(8'h80);
    plain_line(10);
    coast_in = 1'b1;
    step();
    chk(vs_o == 1'b1, "R8 coast high polarity", vs_o, 1);
    coast_in = 1'b0;
    step();
    chk(vs_o == 1'b0, "R8 coast high polarity idle", vs_o, 0);
    wr(8'h82);
    plain_line(10);
    coast_in = 1'b0;
    step();
    chk(vs_o == 1'b1, "R8 coast low polarity", vs_o, 1);
    coast_in = 1'b1;
    step();
    chk(vs_o == 1'b0, "R8 coast low polarity idle", vs_o, 0);
    wr(8'h00);
    plain_line(10);
    vsync_in = 1'b1;
    coast_in = 1'b1;
    step();
    chk(vs_o == 1'b1, "R8 vs carries vsync", vs_o, 1);
    vsync_in = 1'b0;
    step();
    chk(vs_o == 1'b0, "R8 vs ignores coast", vs_o, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule